// File: doc/BRIEF.md
# Floating-Point Operand Specifier Decoder

This block sits in front of a floating-point operate emulation or execution path. It receives a 32-bit instruction word together with the pending floating-point fault kind, which is the 3-bit trap-type field of the floating-point status register. It also receives two flags that say whether the lower and upper halves of the floating-point register file hold saved, valid state.

The block first decides whether the instruction is a floating-point operate instruction that it knows. It then checks that the pending fault kind is one this opcode can raise. For each of the three operands (two sources and one destination) it pulls out the 5-bit register specifier. It maps that specifier to a 6-bit physical register index according to the operand's width: single, double or quad. A per-opcode table gives the width of each operand.

The outputs tell the next stage:
- whether to go ahead;
- which physical registers to touch;
- whether each source must be read as zero because its register-file half was never saved;
- which half-file dirty flag the destination write sets;
- the value to write back into the trap-type field.

An illegal quad specifier turns into an invalid-register fault code. All results are registered and appear one cycle after the request.

Top module: `fp_regspec_decode`

## Requirements
- R1: An instruction is recognised only if (instr AND 0xC1F80000) equals 0x81A00000 (arithmetic group) or 0x81A80000 (compare group). The 9-bit opcode in bits 13:5 must also be listed for that group. The compare group lists only opcodes 0x053 and 0x057. Anything else gives accepted=0 and fault_kind_next equal to the fault_kind input.
- R2: The first source specifier is taken from bits 18:14, the second source from bits 4:0 and the destination from bits 29:25.
- R3: A single-width operand's physical index equals its specifier, zero-extended to 6 bits.
- R4: A double- or quad-width operand's physical index is {spec[0], spec[4:1], 0}.
- R5: A quad-width operand whose specifier has bit 1 set makes bad_spec=1, accepted=0 and fault_kind_next=6. No dirty mark is raised.
- R6: Quad-group opcodes require fault_kind=3. Single and double arithmetic and conversions require fault_kind=2. Single and double square root accept 2 or 3. On a mismatch: accepted=0, bad_spec=0, and fault_kind_next equals the fault_kind input.
- R7: When the fault kind matches and no specifier is illegal, accepted=1 and fault_kind_next=0.
- R8: src1_zero or src2_zero is 1 when that source is present and its index lies in a half that is not saved. Indices 0..31 belong to the lower half (saved_lo) and 32..63 to the upper half (saved_hi).
- R9: On an accepted request with a destination, mark_lo=1 if the destination index is below 32, otherwise mark_hi=1. Compare opcodes have no destination and raise no mark.
- R10: out_valid rises one clock after in_valid. All index, zero and mark outputs are 0 for absent operands and for requests that are not accepted. Back-to-back requests each give one result.
- R11: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe for the current instruction |
| instr | input | 32 | Instruction word |
| fault_kind | input | 3 | Pending trap-type field |
| saved_lo | input | 1 | Lower register-file half holds saved state |
| saved_hi | input | 1 | Upper register-file half holds saved state |
| out_valid | output | 1 | Result present |
| accepted | output | 1 | Operation may proceed |
| bad_spec | output | 1 | Illegal quad specifier detected |
| fault_kind_next | output | 3 | Value to write back into the trap-type field |
| src1_idx | output | 6 | Physical index of first source |
| src2_idx | output | 6 | Physical index of second source |
| dst_idx | output | 6 | Physical index of destination |
| src1_zero | output | 1 | First source reads as zero |
| src2_zero | output | 1 | Second source reads as zero |
| mark_lo | output | 1 | Destination dirties the lower half |
| mark_hi | output | 1 | Destination dirties the upper half |

## Verification
A wrong width-table entry or a wrong fold of the specifier shows up as a wrong physical index. It may also show up as a spurious bad_spec or a wrong dirty-half flag, on the very result registered one cycle after the request. A slip in the fault-kind match appears on that same result as a flipped accepted bit and a fault_kind_next that either clears the field or keeps it when it should not. Because no state carries between requests, every fault is visible on the first request that exercises it. The bench therefore sends back-to-back requests and checks each result against an independent model.

// File: rtl/fpdec_pkg.sv
package fpdec_pkg;

  typedef enum logic [1:0] {
    W_NONE = 2'd0,
    W_SGL  = 2'd1,
    W_DBL  = 2'd2,
    W_QUAD = 2'd3
  } opw_e;

  typedef struct packed {
    logic known;
    logic take_sub;
    logic take_quad;
    opw_e w_dst;
    opw_e w_src2;
    opw_e w_src1;
  } opinfo_t;

  localparam int unsigned FAULT_W     = 3;
  localparam logic [FAULT_W-1:0] FK_SUB    = 3'd2;
  localparam logic [FAULT_W-1:0] FK_QUAD   = 3'd3;
  localparam logic [FAULT_W-1:0] FK_BADREG = 3'd6;

  localparam int unsigned OPF_LSB = 5;
  localparam int unsigned OPF_W   = 9;
  localparam int unsigned S1_LSB  = 14;
  localparam int unsigned S2_LSB  = 0;
  localparam int unsigned D_LSB   = 25;

  localparam logic [31:0] GRP_MASK  = 32'hC1F8_0000;
  localparam logic [31:0] GRP_ARITH = 32'h81A0_0000;
  localparam logic [31:0] GRP_CMP   = 32'h81A8_0000;

  function automatic opinfo_t mk(input logic sub, input logic quad,
                                 input opw_e d, input opw_e s2, input opw_e s1);
    opinfo_t r;
    r.known     = 1'b1;
    r.take_sub  = sub;
    r.take_quad = quad;
    r.w_dst     = d;
    r.w_src2    = s2;
    r.w_src1    = s1;
    return r;
  endfunction

  function automatic opinfo_t lookup(input logic cmp_grp, input logic [OPF_W-1:0] opf);
    opinfo_t r;
    r = '0;
    if (cmp_grp) begin
      case (opf)
        9'h053, 9'h057: r = mk(1'b0, 1'b1, W_NONE, W_QUAD, W_QUAD);
        default:        r = '0;
      endcase
    end else begin
      case (opf)
        9'h003, 9'h007, 9'h00b, 9'h02b:
                        r = mk(1'b0, 1'b1, W_QUAD, W_QUAD, W_NONE);
        9'h043, 9'h047, 9'h04b, 9'h04f:
                        r = mk(1'b0, 1'b1, W_QUAD, W_QUAD, W_QUAD);
        9'h06e:         r = mk(1'b0, 1'b1, W_QUAD, W_DBL,  W_DBL);
        9'h083, 9'h0cb: r = mk(1'b0, 1'b1, W_DBL,  W_QUAD, W_NONE);
        9'h08c, 9'h0ce: r = mk(1'b0, 1'b1, W_QUAD, W_DBL,  W_NONE);
        9'h0c7, 9'h0d3: r = mk(1'b0, 1'b1, W_SGL,  W_QUAD, W_NONE);
        9'h0cc, 9'h0cd: r = mk(1'b0, 1'b1, W_QUAD, W_SGL,  W_NONE);
        9'h029:         r = mk(1'b1, 1'b1, W_SGL,  W_SGL,  W_NONE);
        9'h02a:         r = mk(1'b1, 1'b1, W_DBL,  W_DBL,  W_NONE);
        9'h041, 9'h045, 9'h049, 9'h04d:
                        r = mk(1'b1, 1'b0, W_SGL,  W_SGL,  W_SGL);
        9'h042, 9'h046, 9'h04a, 9'h04e:
                        r = mk(1'b1, 1'b0, W_DBL,  W_DBL,  W_DBL);
        9'h069:         r = mk(1'b1, 1'b0, W_DBL,  W_SGL,  W_SGL);
        9'h081, 9'h0c9, 9'h0c8:
                        r = mk(1'b1, 1'b0, W_DBL,  W_SGL,  W_NONE);
        9'h082, 9'h088: r = mk(1'b1, 1'b0, W_DBL,  W_DBL,  W_NONE);
        9'h0c6, 9'h0d2, 9'h084:
                        r = mk(1'b1, 1'b0, W_SGL,  W_DBL,  W_NONE);
        9'h0d1:         r = mk(1'b1, 1'b0, W_SGL,  W_SGL,  W_NONE);
        default:        r = '0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/fpdec_optable.sv
module fpdec_optable
  import fpdec_pkg::*;
#(
  parameter int unsigned INSN_W = 32
) (
  input  logic [INSN_W-1:0] instr,
  output opinfo_t           info
);
  logic is_arith;
  logic is_cmp;
  logic [OPF_W-1:0] opf;
  opinfo_t raw;

  always_comb begin
    is_arith = ((instr & GRP_MASK) == GRP_ARITH);
    is_cmp   = ((instr & GRP_MASK) == GRP_CMP);
    opf      = instr[OPF_LSB +: OPF_W];
    raw      = lookup(is_cmp, opf);
    info     = (is_arith || is_cmp) ? raw : '0;
  end
endmodule

// File: rtl/fpdec_specmap.sv
module fpdec_specmap
  import fpdec_pkg::*;
#(
  parameter int unsigned SPEC_W = 5,
  localparam int unsigned IDX_W = SPEC_W + 1
) (
  input  logic [SPEC_W-1:0] spec,
  input  opw_e              width,
  input  logic              saved_lo,
  input  logic              saved_hi,
  output logic [IDX_W-1:0]  idx,
  output logic              present,
  output logic              illegal,
  output logic              upper,
  output logic              reads_zero
);
  always_comb begin
    present = (width != W_NONE);
    unique case (width)
      W_NONE:  idx = '0;
      W_SGL:   idx = {1'b0, spec};
      default: idx = {spec[0], spec[SPEC_W-1:1], 1'b0};
    endcase
    illegal    = (width == W_QUAD) && spec[1];
    upper      = idx[IDX_W-1];
    reads_zero = present && (upper ? !saved_hi : !saved_lo);
  end
endmodule

// File: rtl/fp_regspec_decode.sv
module fp_regspec_decode
  import fpdec_pkg::*;
#(
  parameter int unsigned INSN_W = 32,
  parameter int unsigned SPEC_W = 5,
  localparam int unsigned IDX_W = SPEC_W + 1,
  localparam int unsigned N_OPS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INSN_W-1:0]  instr,
  input  logic [FAULT_W-1:0] fault_kind,
  input  logic               saved_lo,
  input  logic               saved_hi,
  output logic               out_valid,
  output logic               accepted,
  output logic               bad_spec,
  output logic [FAULT_W-1:0] fault_kind_next,
  output logic [IDX_W-1:0]   src1_idx,
  output logic [IDX_W-1:0]   src2_idx,
  output logic [IDX_W-1:0]   dst_idx,
  output logic               src1_zero,
  output logic               src2_zero,
  output logic               mark_lo,
  output logic               mark_hi
);
  localparam int unsigned OP_S1 = 0;
  localparam int unsigned OP_S2 = 1;
  localparam int unsigned OP_D  = 2;

  opinfo_t info;
  logic [SPEC_W-1:0] spec_a  [N_OPS];
  opw_e              width_a [N_OPS];
  logic [IDX_W-1:0]  idx_a   [N_OPS];
  logic [N_OPS-1:0]  pres_a, ill_a, up_a, zero_a;

  fpdec_optable #(.INSN_W(INSN_W)) u_table (
    .instr (instr),
    .info  (info)
  );

  always_comb begin
    spec_a[OP_S1]  = instr[S1_LSB +: SPEC_W];
    spec_a[OP_S2]  = instr[S2_LSB +: SPEC_W];
    spec_a[OP_D]   = instr[D_LSB  +: SPEC_W];
    width_a[OP_S1] = info.w_src1;
    width_a[OP_S2] = info.w_src2;
    width_a[OP_D]  = info.w_dst;
  end

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fpdec_specmap #(.SPEC_W(SPEC_W)) u_map (
      .spec       (spec_a[g]),
      .width      (width_a[g]),
      .saved_lo   (saved_lo),
      .saved_hi   (saved_hi),
      .idx        (idx_a[g]),
      .present    (pres_a[g]),
      .illegal    (ill_a[g]),
      .upper      (up_a[g]),
      .reads_zero (zero_a[g])
    );
  end

  // next-state
  logic kind_ok, any_ill, go;
  logic               acc_d, bad_d, z1_d, z2_d, mlo_d, mhi_d;
  logic [FAULT_W-1:0] fk_d;
  logic [IDX_W-1:0]   i1_d, i2_d, id_d;

  always_comb begin
    kind_ok = info.known &&
              ((info.take_sub  && (fault_kind == FK_SUB)) ||
               (info.take_quad && (fault_kind == FK_QUAD)));
    any_ill = |ill_a;
    go      = kind_ok && !any_ill;
    acc_d   = in_valid && go;
    bad_d   = in_valid && kind_ok && any_ill;
    if (!kind_ok)     fk_d = fault_kind;
    else if (any_ill) fk_d = FK_BADREG;
    else              fk_d = '0;
    i1_d  = go ? idx_a[OP_S1] : '0;
    i2_d  = go ? idx_a[OP_S2] : '0;
    id_d  = go ? idx_a[OP_D]  : '0;
    z1_d  = acc_d && zero_a[OP_S1];
    z2_d  = acc_d && zero_a[OP_S2];
    mlo_d = acc_d && pres_a[OP_D] && !up_a[OP_D];
    mhi_d = acc_d && pres_a[OP_D] &&  up_a[OP_D];
  end

  // flag registers: follow the request every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      accepted  <= 1'b0;
      bad_spec  <= 1'b0;
      src1_zero <= 1'b0;
      src2_zero <= 1'b0;
      mark_lo   <= 1'b0;
      mark_hi   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      accepted  <= acc_d;
      bad_spec  <= bad_d;
      src1_zero <= z1_d;
      src2_zero <= z2_d;
      mark_lo   <= mlo_d;
      mark_hi   <= mhi_d;
    end
  end

  // payload registers: loaded only on a request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_kind_next <= '0;
      src1_idx        <= '0;
      src2_idx        <= '0;
      dst_idx         <= '0;
    end else if (in_valid) begin
      fault_kind_next <= fk_d;
      src1_idx        <= i1_d;
      src2_idx        <= i2_d;
      dst_idx         <= id_d;
    end
  end

  assert_badreg_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_spec |-> (fault_kind_next == FK_BADREG) && !accepted && !mark_lo && !mark_hi);

  assert_clear_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |-> (fault_kind_next == '0) && !bad_spec);

  assert_one_half_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mark_lo, mark_hi}));

  assert_mark_follows_index_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mark_hi |-> dst_idx[IDX_W-1]);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !accepted && !bad_spec && !mark_lo && !mark_hi);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_mismatch_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !kind_ok) |=> (fault_kind_next == $past(fault_kind)) && !accepted);
endmodule

// File: tb/fp_regspec_decode_test.sv
module fp_regspec_decode_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [2:0]  fault_kind;
  logic        saved_lo, saved_hi;
  logic        out_valid, accepted, bad_spec, src1_zero, src2_zero, mark_lo, mark_hi;
  logic [2:0]  fault_kind_next;
  logic [5:0]  src1_idx, src2_idx, dst_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp_regspec_decode uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .fault_kind(fault_kind), .saved_lo(saved_lo), .saved_hi(saved_hi),
    .out_valid(out_valid), .accepted(accepted), .bad_spec(bad_spec),
    .fault_kind_next(fault_kind_next), .src1_idx(src1_idx), .src2_idx(src2_idx),
    .dst_idx(dst_idx), .src1_zero(src1_zero), .src2_zero(src2_zero),
    .mark_lo(mark_lo), .mark_hi(mark_hi)
  );

  typedef struct {
    string      tag;
    logic       acc, bad, z1, z2, mlo, mhi;
    logic [2:0] fk;
    logic [5:0] i1, i2, id;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // width codes: 0 none, 1 single, 2 double, 3 quad; k2/k3 = accepts fault kind 2/3
  function automatic void widths(input logic cmp, input logic [8:0] opf,
      output bit known, output bit k2, output bit k3,
      output int wd, output int w2, output int w1);
    known = 1; k2 = 0; k3 = 0; wd = 0; w2 = 0; w1 = 0;
    if (cmp) begin
      if (opf == 9'h053 || opf == 9'h057) begin k3 = 1; w2 = 3; w1 = 3; end
      else known = 0;
    end else begin
      case (opf)
        9'h003, 9'h007, 9'h00b, 9'h02b: begin k3 = 1; wd = 3; w2 = 3; end
        9'h043, 9'h047, 9'h04b, 9'h04f: begin k3 = 1; wd = 3; w2 = 3; w1 = 3; end
        9'h06e: begin k3 = 1; wd = 3; w2 = 2; w1 = 2; end
        9'h083, 9'h0cb: begin k3 = 1; wd = 2; w2 = 3; end
        9'h08c, 9'h0ce: begin k3 = 1; wd = 3; w2 = 2; end
        9'h0c7, 9'h0d3: begin k3 = 1; wd = 1; w2 = 3; end
        9'h0cc, 9'h0cd: begin k3 = 1; wd = 3; w2 = 1; end
        9'h029: begin k2 = 1; k3 = 1; wd = 1; w2 = 1; end
        9'h02a: begin k2 = 1; k3 = 1; wd = 2; w2 = 2; end
        9'h041, 9'h045, 9'h049, 9'h04d: begin k2 = 1; wd = 1; w2 = 1; w1 = 1; end
        9'h042, 9'h046, 9'h04a, 9'h04e: begin k2 = 1; wd = 2; w2 = 2; w1 = 2; end
        9'h069: begin k2 = 1; wd = 2; w2 = 1; w1 = 1; end
        9'h081, 9'h0c9, 9'h0c8: begin k2 = 1; wd = 2; w2 = 1; end
        9'h082, 9'h088: begin k2 = 1; wd = 2; w2 = 2; end
        9'h0c6, 9'h0d2, 9'h084: begin k2 = 1; wd = 1; w2 = 2; end
        9'h0d1: begin k2 = 1; wd = 1; w2 = 1; end
        default: known = 0;
      endcase
    end
  endfunction

  function automatic logic [5:0] phys(input logic [4:0] s, input int w);
    if (w == 0) return 6'd0;
    if (w == 1) return {1'b0, s};
    return {s[0], s[4:1], 1'b0};
  endfunction

  function automatic exp_t model(input string tag, input logic [31:0] ins,
                                 input logic [2:0] fk, input logic slo, input logic shi);
    exp_t e;
    bit g1, g2, known, k2, k3, ok, ill;
    int wd, w2, w1;
    logic [5:0] p1, p2, pd;
    e.tag = tag;
    g1 = ((ins & 32'hC1F80000) == 32'h81A00000);
    g2 = ((ins & 32'hC1F80000) == 32'h81A80000);
    widths(g2, ins[13:5], known, k2, k3, wd, w2, w1);
    ok  = (g1 || g2) && known && ((k2 && fk == 3'd2) || (k3 && fk == 3'd3));
    ill = (w1 == 3 && ins[15]) || (w2 == 3 && ins[1]) || (wd == 3 && ins[26]);
    p1 = phys(ins[18:14], w1);
    p2 = phys(ins[4:0], w2);
    pd = phys(ins[29:25], wd);
    e.acc = ok && !ill;
    e.bad = ok && ill;
    e.fk  = !ok ? fk : (ill ? 3'd6 : 3'd0);
    e.i1  = e.acc ? p1 : 6'd0;
    e.i2  = e.acc ? p2 : 6'd0;
    e.id  = e.acc ? pd : 6'd0;
    e.z1  = e.acc && w1 != 0 && (p1[5] ? !shi : !slo);
    e.z2  = e.acc && w2 != 0 && (p2[5] ? !shi : !slo);
    e.mlo = e.acc && wd != 0 && !pd[5];
    e.mhi = e.acc && wd != 0 &&  pd[5];
    return e;
  endfunction

  function automatic logic [31:0] mk(input bit cmp, input logic [4:0] d,
                                     input logic [4:0] s1, input logic [8:0] opf,
                                     input logic [4:0] s2);
    return {2'b10, d, (cmp ? 6'h35 : 6'h34), s1, opf, s2};
  endfunction

  task automatic send(input string tag, input logic [31:0] ins, input logic [2:0] fk,
                      input logic slo, input logic shi);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; fault_kind = fk; saved_lo = slo; saved_hi = shi;
    sb.push_back(model(tag, ins, fk, slo, shi));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: result appears one edge after the request (R10)
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (sb.size() == 0) begin
        chk("R10", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, "/R7"}, "accepted", accepted, e.acc);
        chk({e.tag, "/R5"}, "bad_spec", bad_spec, e.bad);
        chk({e.tag, "/R6"}, "fault_kind_next", fault_kind_next, e.fk);
        chk({e.tag, "/R2"}, "src1_idx", src1_idx, e.i1);
        chk({e.tag, "/R4"}, "src2_idx", src2_idx, e.i2);
        chk({e.tag, "/R3"}, "dst_idx", dst_idx, e.id);
        chk({e.tag, "/R8"}, "src1_zero", src1_zero, e.z1);
        chk({e.tag, "/R8"}, "src2_zero", src2_zero, e.z2);
        chk({e.tag, "/R9"}, "mark_lo", mark_lo, e.mlo);
        chk({e.tag, "/R9"}, "mark_hi", mark_hi, e.mhi);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; fault_kind = '0;
    saved_lo = 1'b0; saved_hi = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs held at zero during reset
    chk("R11", "out_valid", out_valid, 0);
    chk("R11", "accepted", accepted, 0);
    chk("R11", "fault_kind_next", fault_kind_next, 0);
    chk("R11", "dst_idx", dst_idx, 0);
    chk("R11", "marks", {mark_lo, mark_hi}, 0);
    rst_n = 1'b1;
    idle(2);

    // R3 single mapping, lower half mark
    send("R3_single_add", mk(0, 5'd5, 5'd31, 9'h041, 5'd0), 3'd2, 1, 1);
    // R4 double fold: dst 3->34 upper, src2 31->62 unsaved upper -> zero (R8)
    send("R4_double_add", mk(0, 5'd3, 5'd6, 9'h042, 5'd31), 3'd2, 1, 0);
    // R4 quad fold, legal specifiers
    send("R4_quad_add", mk(0, 5'd4, 5'd9, 9'h043, 5'd1), 3'd3, 1, 1);
    // R5 illegal quad source2 / destination / source1
    send("R5_bad_src2", mk(0, 5'd4, 5'd9, 9'h043, 5'd2), 3'd3, 1, 1);
    send("R5_bad_dst", mk(0, 5'd6, 5'd9, 9'h04b, 5'd1), 3'd3, 1, 1);
    send("R5_bad_src1", mk(1, 5'd0, 5'd3, 9'h053, 5'd0), 3'd3, 1, 1);
    // R6 fault kind mismatches
    send("R6_quad_wrong_kind", mk(0, 5'd4, 5'd9, 9'h043, 5'd1), 3'd2, 1, 1);
    send("R6_single_wrong_kind", mk(0, 5'd5, 5'd1, 9'h041, 5'd2), 3'd3, 1, 1);
    send("R6_sqrt_kind3", mk(0, 5'd7, 5'd0, 9'h029, 5'd8), 3'd3, 1, 1);
    send("R6_sqrt_kind2", mk(0, 5'd7, 5'd0, 9'h02a, 5'd9), 3'd2, 0, 1);
    send("R6_sqrt_kind0", mk(0, 5'd7, 5'd0, 9'h029, 5'd8), 3'd0, 1, 1);
    send("R6_bad_kind_with_bad_spec", mk(0, 5'd6, 5'd2, 9'h043, 5'd2), 3'd2, 1, 1);
    idle(1);
    // R1 group recognition
    send("R1_not_fp", 32'h0000_0000, 3'd3, 1, 1);
    send("R1_unknown_opf", mk(0, 5'd1, 5'd1, 9'h1ff, 5'd1), 3'd2, 1, 1);
    send("R1_arith_in_cmp_group", mk(1, 5'd5, 5'd1, 9'h041, 5'd2), 3'd2, 1, 1);
    send("R1_cmp_quad", mk(1, 5'd2, 5'd12, 9'h057, 5'd17), 3'd3, 1, 0);
    // mixed widths, absent source1, R7 clear on success
    send("R7_dmulq", mk(0, 5'd8, 5'd3, 9'h06e, 5'd7), 3'd3, 0, 1);
    send("R10_itod_no_src1", mk(0, 5'd11, 5'd21, 9'h0c8, 5'd30), 3'd2, 0, 0);
    send("R8_stoi_unsaved_lo", mk(0, 5'd31, 5'd0, 9'h0d1, 5'd14), 3'd2, 0, 1);
    send("R9_qtos_lo", mk(0, 5'd20, 5'd0, 9'h0c7, 5'd13), 3'd3, 1, 1);
    idle(3);

    chk("R10", "leftover expected results", sb.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule